// File: doc/BRIEF.md
# Transmit Completion Status Stack

This block keeps the outcome of finished transmit frames in a small last-in-first-out stack of 8-bit status bytes. The transmit engine presents one report per finished frame, with a flag asking for an interrupt on success and flags for the error kinds. The block stores a report only when it is worth the host's attention, either because the frame failed or because the engine asked for an interrupt. Each stored report raises a one-cycle completion event.

The host sees the top entry on a byte read port at all times. A write strobe on that same port discards the top entry, so the entry below it becomes visible. When the stack is already full, a new report is not stored. Instead, the overflow bit of the entry on top is set.

A jabber or underrun report locks the transmitter. While the lock is set, further reports are ignored. A transmit reset empties the stack and releases the lock.

Top module: `txstat_lifo`

## Requirements
- R1: A stored entry has bit 7 = 1 (complete), bit 6 = interrupt requested, bit 5 = jabber, bit 4 = underrun, bit 3 = maximum collisions, bit 2 = overflow, and bits 1:0 = 0.
- R2: A report is stored only when at least one of irq_req, jabber, underrun or maxcoll is set. A report with all four flags clear leaves the stack unchanged.
- R3: When the stack is empty, host_rd_data reads 8'h00.
- R4: A host_pop strobe removes the top entry, so the previously pushed entry shows on the following cycle. A pop on an empty stack has no effect.
- R5: A report that qualifies for storage while the stack holds DEPTH entries (and with no pop in the same cycle) is dropped. Bit 2 of the top entry is set, and all other entries are unchanged.
- R6: A qualifying report together with a pop on a non-empty stack replaces the top entry with the new one, and the number of entries stays the same.
- R7: A qualifying report with jabber or underrun set raises tx_locked from the next cycle. tx_locked then stays high until a transmit reset, and reports presented while it is high are ignored.
- R8: A tx_reset empties the stack and clears tx_locked on the next cycle. It takes priority over a push, a pop, or a lock request in the same cycle.
- R9: cmpl_evt is high for one cycle, in the cycle after each qualifying report accepted with no tx_reset. This includes a report that is dropped because the stack is full.
- R10: After reset, host_rd_data is 8'h00 and tx_locked and cmpl_evt are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| done_valid | input | 1 | Transmit engine presents a finished-frame report |
| done_irq_req | input | 1 | Interrupt requested on successful transmission |
| done_jabber | input | 1 | Jabber error on this frame |
| done_underrun | input | 1 | Underrun on this frame |
| done_maxcoll | input | 1 | Frame abandoned after maximum collisions |
| host_pop | input | 1 | Host write strobe on the status port; pops the top entry |
| tx_reset | input | 1 | Transmit reset command |
| host_rd_data | output | 8 | Top status entry, 8'h00 when empty |
| tx_locked | output | 1 | Transmitter held off by a fatal error |
| cmpl_evt | output | 1 | One-cycle transmit-complete event |

## Verification
The assertions assume that the inputs carry known values after reset. They also assume that the flag inputs matter only in a cycle where done_valid is high. No ordering between host_pop, tx_reset and done_valid is assumed, because same-cycle collisions of these inputs are themselves required behaviour.

The stimulus drives every input with a defined value in every cycle. Directed phases cover the same-cycle combinations on purpose. A long pseudo-random phase then drives these collisions freely, with tx_reset kept rare so that the stack can fill and the overflow path is reached.

// File: rtl/txstat_pkg.sv
package txstat_pkg;

   localparam int STAT_W = 8;

   localparam int B_DONE  = 7;
   localparam int B_IRQ   = 6;
   localparam int B_JAB   = 5;
   localparam int B_UND   = 4;
   localparam int B_MAXC  = 3;
   localparam int B_OVF   = 2;

   typedef logic [STAT_W-1:0] stat_byte_t;

   function automatic stat_byte_t make_entry(input logic irq, input logic jab,
                                             input logic und, input logic maxc);
      stat_byte_t e;
      e         = '0;
      e[B_DONE] = 1'b1;
      e[B_IRQ]  = irq;
      e[B_JAB]  = jab;
      e[B_UND]  = und;
      e[B_MAXC] = maxc;
      return e;
   endfunction

endpackage

// File: rtl/txstat_entry_fmt.sv
module txstat_entry_fmt
   import txstat_pkg::*;
(
   input  logic       valid,
   input  logic       irq_req,
   input  logic       jabber,
   input  logic       underrun,
   input  logic       maxcoll,
   input  logic       locked,
   output logic       qualify,
   output logic       fatal,
   output stat_byte_t entry
);

   logic any_err;

   always_comb begin
      any_err = jabber | underrun | maxcoll;
      // a report is kept when it failed or asked for an interrupt
      qualify = valid & ~locked & (any_err | irq_req);
      fatal   = qualify & (jabber | underrun);
      entry   = make_entry(irq_req, jabber, underrun, maxcoll);
   end

endmodule

// File: rtl/txstat_stack.sv
module txstat_stack
   import txstat_pkg::*;
#(
   parameter int DEPTH = 4
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       push_en,
   input  logic       pop_en,
   input  stat_byte_t push_data,
   output stat_byte_t top
);

   localparam int            CW   = $clog2(DEPTH + 1);
   localparam logic [CW-1:0] FULL = CW'(DEPTH);
   localparam logic [CW-1:0] ONE  = CW'(1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("txstat_stack: DEPTH must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   stat_byte_t    slot_q [DEPTH];
   stat_byte_t    from_above [DEPTH];
   stat_byte_t    from_below [DEPTH];

   logic is_empty, is_full;
   logic do_push, do_pop, do_repl, do_ovf;

   always_comb begin
      is_empty = (cnt_q == '0);
      is_full  = (cnt_q == FULL);
      do_repl  = push_en &  pop_en & ~is_empty;
      do_push  = push_en & ~do_repl & ~is_full;
      do_ovf   = push_en & ~pop_en & is_full;
      do_pop   = pop_en  & ~push_en & ~is_empty;
   end

   genvar i;
   generate
      for (i = 0; i < DEPTH; i++) begin : g_slot
         if (i == 0) begin : g_head
            assign from_above[i] = push_data;
         end else begin : g_body
            assign from_above[i] = slot_q[i-1];
         end
         if (i == DEPTH - 1) begin : g_tail
            assign from_below[i] = '0;
         end else begin : g_inner
            assign from_below[i] = slot_q[i+1];
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               slot_q[i] <= '0;
            end else if (clr) begin
               slot_q[i] <= '0;
            end else if (do_push) begin
               slot_q[i] <= from_above[i];
            end else if (do_pop) begin
               slot_q[i] <= from_below[i];
            end else if (do_repl && i == 0) begin
               slot_q[i] <= push_data;
            end else if (do_ovf && i == 0) begin
               slot_q[i] <= slot_q[i] | (STAT_W'(1) << B_OVF);
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (do_push) begin
         cnt_q <= cnt_q + ONE;
      end else if (do_pop) begin
         cnt_q <= cnt_q - ONE;
      end
   end

   assign top = slot_q[0];

   // R3: an empty stack reads as zero
   a_r3_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0) |-> (top == '0));

   // R5: a push into a full stack keeps the depth and marks the top entry
   a_r5_full_push_marks_ovf: assert property (@(posedge clk) disable iff (!rst_n)
      (push_en && !pop_en && cnt_q == FULL && !clr) |=> (cnt_q == FULL && top[B_OVF]));

   // R6: push with pop on a non-empty stack swaps the top
   a_r6_replace_keeps_depth: assert property (@(posedge clk) disable iff (!rst_n)
      (push_en && pop_en && cnt_q != '0 && !clr) |=>
         (cnt_q == $past(cnt_q) && top == $past(push_data)));

   // R8: clear leaves nothing behind
   a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0 && top == '0));

endmodule

// File: rtl/txstat_fatal_lock.sv
module txstat_fatal_lock (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic locked
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked <= 1'b0;
      end else if (clr) begin
         locked <= 1'b0;
      end else if (set) begin
         locked <= 1'b1;
      end
   end

   // R7: once set the lock only falls through a transmit reset
   a_r7_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && !clr) |=> locked);

   // R8: transmit reset releases the lock
   a_r8_clear_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !locked);

endmodule

// File: rtl/txstat_lifo.sv
module txstat_lifo
   import txstat_pkg::*;
#(
   parameter int DEPTH = 4
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       done_valid,
   input  logic       done_irq_req,
   input  logic       done_jabber,
   input  logic       done_underrun,
   input  logic       done_maxcoll,
   input  logic       host_pop,
   input  logic       tx_reset,
   output logic [7:0] host_rd_data,
   output logic       tx_locked,
   output logic       cmpl_evt
);

   logic       rpt_qual;
   logic       rpt_fatal;
   stat_byte_t rpt_entry;
   stat_byte_t top_entry;
   logic       evt_q;

   txstat_entry_fmt u_fmt (
      .valid    (done_valid),
      .irq_req  (done_irq_req),
      .jabber   (done_jabber),
      .underrun (done_underrun),
      .maxcoll  (done_maxcoll),
      .locked   (tx_locked),
      .qualify  (rpt_qual),
      .fatal    (rpt_fatal),
      .entry    (rpt_entry)
   );

   txstat_stack #(.DEPTH(DEPTH)) u_stack (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (tx_reset),
      .push_en   (rpt_qual & ~tx_reset),
      .pop_en    (host_pop),
      .push_data (rpt_entry),
      .top       (top_entry)
   );

   txstat_fatal_lock u_lock (
      .clk    (clk),
      .rst_n  (rst_n),
      .set    (rpt_fatal),
      .clr    (tx_reset),
      .locked (tx_locked)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_q <= 1'b0;
      end else begin
         evt_q <= rpt_qual & ~tx_reset;
      end
   end

   assign cmpl_evt     = evt_q;
   assign host_rd_data = top_entry;

   // R9: every event traces back to an accepted report
   a_r9_evt_from_report: assert property (@(posedge clk) disable iff (!rst_n)
      cmpl_evt |-> $past(done_valid && !tx_locked && !tx_reset));

   // R1: the two undefined bits never read as one
   a_r1_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
      host_rd_data[1:0] == 2'b00);

   // R1: any non-zero entry carries the complete bit
   a_r1_complete_set: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd_data != 8'h00) |-> host_rd_data[7]);

endmodule

// File: tb/txstat_lifo_tb.sv
module txstat_lifo_tb;

   localparam int DEPTH = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       done_valid = 1'b0, done_irq_req = 1'b0, done_jabber = 1'b0;
   logic       done_underrun = 1'b0, done_maxcoll = 1'b0;
   logic       host_pop = 1'b0, tx_reset = 1'b0;
   logic [7:0] host_rd_data;
   logic       tx_locked, cmpl_evt;

   int n_vec  = 0;
   int n_miss = 0;
   bit finished = 0;

   logic [7:0] mq [$];
   bit         m_lock = 0;
   bit         m_evt  = 0;

   always #5 clk = ~clk;

   txstat_lifo #(.DEPTH(DEPTH)) u_dut (
      .clk (clk), .rst_n (rst_n),
      .done_valid (done_valid), .done_irq_req (done_irq_req),
      .done_jabber (done_jabber), .done_underrun (done_underrun),
      .done_maxcoll (done_maxcoll), .host_pop (host_pop),
      .tx_reset (tx_reset), .host_rd_data (host_rd_data),
      .tx_locked (tx_locked), .cmpl_evt (cmpl_evt)
   );

   task automatic compare(input string tag);
      logic [7:0] exp_top;
      exp_top = (mq.size() != 0) ? mq[0] : 8'h00;
      n_vec++;
      if (host_rd_data !== exp_top) begin
         n_miss++;
         $display("FAIL %s host_rd_data got %h exp %h", tag, host_rd_data, exp_top);
      end
      if (tx_locked !== m_lock) begin
         n_miss++;
         $display("FAIL R7 tx_locked got %b exp %b", tx_locked, m_lock);
      end
      if (cmpl_evt !== m_evt) begin
         n_miss++;
         $display("FAIL R9 cmpl_evt got %b exp %b", cmpl_evt, m_evt);
      end
   endtask

   // compare outputs, drive one cycle of inputs, advance the model
   task automatic step(input string tag, input bit v, input bit irq, input bit jab,
                       input bit und, input bit mc, input bit pop, input bit rst);
      bit         qual;
      logic [7:0] e;
      @(negedge clk);
      compare(tag);
      done_valid = v; done_irq_req = irq; done_jabber = jab;
      done_underrun = und; done_maxcoll = mc; host_pop = pop; tx_reset = rst;
      if (rst) begin
         mq.delete();
         m_lock = 0;
         m_evt  = 0;
      end else begin
         qual  = v && !m_lock && (irq || jab || und || mc);
         m_evt = qual;
         e = {1'b1, irq, jab, und, mc, 3'b000};
         if (qual && pop && mq.size() != 0) mq[0] = e;
         else if (qual && mq.size() == DEPTH) mq[0] = mq[0] | 8'h04;
         else if (qual) mq.push_front(e);
         else if (pop && mq.size() != 0) void'(mq.pop_front());
         if (qual && (jab || und)) m_lock = 1;
      end
   endtask

   task automatic idle(input string tag, input int n);
      for (int k = 0; k < n; k++) step(tag, 0, 0, 0, 0, 0, 0, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      idle("R10", 2);                           // reset state
      step("R2", 1, 0, 0, 0, 0, 0, 0);          // clean frame, no interrupt: nothing stored
      idle("R2", 2);
      step("R1", 1, 1, 0, 0, 0, 0, 0);          // 8'hC0
      step("R1", 1, 0, 0, 0, 1, 0, 0);          // 8'h88
      step("R4", 0, 0, 0, 0, 0, 1, 0);          // pop reveals 8'hC0
      step("R4", 0, 0, 0, 0, 0, 1, 0);
      step("R3", 0, 0, 0, 0, 0, 1, 0);          // pop on empty ignored
      idle("R3", 2);
      for (int k = 0; k < DEPTH; k++) step("R5", 1, 1, 0, 0, k[0], 0, 0);
      step("R5", 1, 0, 0, 0, 1, 0, 0);          // dropped, overflow bit on top
      idle("R5", 1);
      step("R6", 1, 1, 0, 0, 1, 1, 0);          // replace top when full
      step("R6", 1, 1, 0, 0, 0, 1, 0);
      for (int k = 0; k < DEPTH; k++) step("R4", 0, 0, 0, 0, 0, 1, 0);
      step("R6", 1, 1, 0, 0, 0, 1, 0);          // push+pop on empty acts as push
      step("R7", 1, 0, 1, 0, 0, 0, 0);          // jabber locks
      step("R7", 1, 1, 0, 0, 1, 0, 0);          // ignored while locked
      idle("R7", 2);
      step("R8", 1, 0, 0, 1, 0, 1, 1);          // reset wins over push, pop and lock
      idle("R8", 2);
      step("R7", 1, 0, 0, 1, 0, 0, 0);          // underrun locks
      idle("R7", 1);
      step("R8", 0, 0, 0, 0, 0, 0, 1);
      idle("R8", 1);
      for (int k = 0; k < 4000; k++) begin
         int r;
         r = $urandom_range(0, 99);
         step("R1 R4", ($urandom_range(0, 9) < 6), $urandom_range(0, 1),
              ($urandom_range(0, 29) == 0), ($urandom_range(0, 29) == 0),
              $urandom_range(0, 1), ($urandom_range(0, 9) < 3), (r < 2));
      end
      idle("R9", 2);
      @(negedge clk);
      compare("R9");
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!finished) begin
         n_miss++;
         $display("FAIL watchdog expired got running exp finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
         $finish;
      end
   end

endmodule